// File: doc/BRIEF.md
# Dual Sinc Decimator with Channel Skew

This block turns two streams of five-level delta-sigma modulator codes into signed output words at the decimated data rate. Each channel runs a third-order sinc filter: three integrators advance on every modulator tick, and three combs run once per output period. The oversampling ratio, chosen by a two-bit select, sets both the filter length and the output rate, which is the modulator tick rate divided by the ratio. Results are normalized so that a constant code `c` settles to `c * 2^22`. They saturate at the 24-bit two's-complement limits, and each channel can narrow its word to the upper 16 bits.

A signed phase value shifts one channel against the other by a whole number of modulator ticks. This lets a system line up sensors whose signal paths have different delays. A positive value holds back channel 0, and a negative value holds back channel 1. The usable span is half the oversampling ratio in each direction, and out-of-range values are clamped to that span. The modulator tick is a clock enable, so one system clock serves any modulator rate at or below it.

Top module: `dual_sinc_decimator`

## Requirements
- R1: While `rst_n` is low, both data words read zero and both valid strobes are low.
- R2: With `osr_sel` = 0, 1, 2, 3 the ratio is 32, 64, 128, 256. Exactly that many `mod_tick` pulses separate two valid strobes. Every strobe comes in the cycle after a tick, and cycles without a tick do not advance the filter.
- R3: Codes are 3-bit two's complement, limited to -2..+2. A constant code `c` settles, from the fifth word on, to `c * 2^22` as a 24-bit two's-complement word: +1 gives 0x400000, -1 gives 0xC00000, 0 gives 0x000000.
- R4: Results above 0x7FFFFF are replaced by 0x7FFFFF and results below 0x800000 by 0x800000, so a constant +2 gives 0x7FFFFF and a constant -2 gives 0x800000.
- R5: A channel whose width bit is 1 delivers the full 24-bit word. With width 0 it delivers bits 23..8 of that same word in bits 23..8, with bits 7..0 zero. The width bit of one channel has no effect on the other channel.
- R6: Both channels strobe valid in the same cycle, and each strobe lasts exactly one clock.
- R7: A positive `phase` value P (8-bit two's complement) makes channel 0 behave as if its input arrived P ticks later, while channel 1 is not delayed.
- R8: A negative `phase` value -P makes channel 1 behave as if its input arrived P ticks later, while channel 0 is not delayed.
- R9: `phase` is clamped to the range from -OSR/2 to OSR/2-1. At OSR 32, the value +40 acts as +15 and the value -100 acts as -16.
- R10: A data word holds its value in every cycle in which its valid strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_tick | input | 1 | Modulator clock enable, one pulse per modulator sample |
| osr_sel | input | 2 | Oversampling ratio select: 32, 64, 128, 256 |
| phase | input | 8 | Signed channel skew in modulator ticks |
| width_ch0 | input | 1 | Channel 0 word width: 1 = 24 bits, 0 = 16 bits |
| width_ch1 | input | 1 | Channel 1 word width: 1 = 24 bits, 0 = 16 bits |
| mod_ch0 | input | 3 | Channel 0 modulator code, -2..+2 |
| mod_ch1 | input | 3 | Channel 1 modulator code, -2..+2 |
| data_ch0 | output | 24 | Channel 0 filtered word |
| valid_ch0 | output | 1 | Channel 0 new-word strobe |
| data_ch1 | output | 24 | Channel 1 filtered word |
| valid_ch1 | output | 1 | Channel 1 new-word strobe |

## Verification
The properties assume that `osr_sel`, `phase` and both width bits hold still between resets, since the tick-count and narrow-word checks compare a strobe against the settings in force when it was produced. They also assume that the modulator codes stay inside -2..+2, which is what keeps the integrators free of overflow. The stimulus changes configuration only while reset is held, and it draws every code from a small set of legal values. It checks skew behaviour by comparing a skewed run against an unskewed run with an equally offset input step, so no filter model has to be assumed.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
   // Largest ratio exponent reachable from a select field.
   function automatic int max_log2(input int min_log2, input int sel_w);
      return min_log2 + (1 << sel_w) - 1;
   endfunction
endpackage

// File: rtl/dsd_decim_timer.sv
module dsd_decim_timer #(
   parameter int MIN_OSR_LOG2 = 5,
   parameter int SEL_W        = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_tick,
   input  logic [SEL_W-1:0] osr_sel,
   output logic             dec_stb
);
   localparam int MAX_LOG2 = dsd_pkg::max_log2(MIN_OSR_LOG2, SEL_W);

   logic [MAX_LOG2:0]   osr_val;
   logic [MAX_LOG2-1:0] last_idx;
   logic [MAX_LOG2-1:0] cnt_q;

   always_comb begin
      osr_val  = (MAX_LOG2+1)'(1) << (MIN_OSR_LOG2 + int'(osr_sel));
      last_idx = MAX_LOG2'(osr_val - 1'b1);
   end

   assign dec_stb = mod_tick && (cnt_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (dec_stb)  cnt_q <= '0;
      else if (mod_tick) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/dsd_phase_delay.sv
module dsd_phase_delay #(
   parameter int MIN_OSR_LOG2 = 5,
   parameter int SEL_W        = 2,
   parameter int CODE_W       = 3,
   parameter int PH_W         = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mod_tick,
   input  logic [SEL_W-1:0]         osr_sel,
   input  logic signed [PH_W-1:0]   phase_val,
   input  logic [1:0][CODE_W-1:0]   codes_in,
   output logic [1:0][CODE_W-1:0]   codes_out
);
   localparam int MAX_LOG2 = dsd_pkg::max_log2(MIN_OSR_LOG2, SEL_W);
   localparam int IDX_W    = MAX_LOG2 - 1;
   localparam int DEPTH    = 1 << IDX_W;

   int half_span;
   int ph_cl;
   int dly [2];

   // Clamp the skew to the span allowed by the current ratio.
   always_comb begin
      half_span = 1 << (MIN_OSR_LOG2 - 1 + int'(osr_sel));
      ph_cl     = int'(phase_val);
      if (ph_cl > half_span - 1)  ph_cl = half_span - 1;
      else if (ph_cl < -half_span) ph_cl = -half_span;
      dly[0] = (ph_cl > 0) ? ph_cl : 0;
      dly[1] = (ph_cl < 0) ? -ph_cl : 0;
   end

   for (genvar c = 0; c < 2; c++) begin : g_lane
      logic [CODE_W-1:0] line_q [DEPTH];
      logic [IDX_W-1:0]  tap_idx;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
         end else if (mod_tick) begin
            line_q[0] <= codes_in[c];
            for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
         end
      end

      always_comb begin
         tap_idx      = IDX_W'(dly[c] - 1);
         codes_out[c] = (dly[c] == 0) ? codes_in[c] : line_q[tap_idx];
      end
   end
endmodule

// File: rtl/dsd_sinc3.sv
module dsd_sinc3 #(
   parameter int MIN_OSR_LOG2 = 5,
   parameter int SEL_W        = 2,
   parameter int CODE_W       = 3,
   parameter int OUT_W        = 24,
   parameter int NARROW_W     = 16,
   parameter int ORDER        = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_tick,
   input  logic             dec_stb,
   input  logic [SEL_W-1:0] osr_sel,
   input  logic             wide,
   input  logic [CODE_W-1:0] code,
   output logic [OUT_W-1:0] word,
   output logic             word_vld
);
   localparam int MAX_LOG2 = dsd_pkg::max_log2(MIN_OSR_LOG2, SEL_W);
   localparam int ACC_W    = CODE_W + ORDER * MAX_LOG2;
   localparam int SC_W     = ACC_W + OUT_W;
   localparam logic signed [SC_W-1:0] SAT_HI =
      {{(SC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [SC_W-1:0] SAT_LO =
      {{(SC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [ACC_W-1:0] code_ext;
   logic signed [ACC_W-1:0] integ_q [ORDER];
   logic signed [ACC_W-1:0] comb_z_q [ORDER];
   logic signed [ACC_W-1:0] diff [ORDER];
   logic signed [SC_W-1:0]  wide_v;
   logic signed [SC_W-1:0]  scaled;
   logic [OUT_W-1:0]        sat_w;
   logic [OUT_W-1:0]        trimmed;
   int                      sh;

   assign code_ext = {{(ACC_W-CODE_W){code[CODE_W-1]}}, code};

   // Integrators at the modulator rate; wrap-around is harmless.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ORDER; i++) integ_q[i] <= '0;
      end else if (mod_tick) begin
         integ_q[0] <= integ_q[0] + code_ext;
         for (int i = 1; i < ORDER; i++) integ_q[i] <= integ_q[i] + integ_q[i-1];
      end
   end

   always_comb begin
      diff[0] = integ_q[ORDER-1] - comb_z_q[0];
      for (int i = 1; i < ORDER; i++) diff[i] = diff[i-1] - comb_z_q[i];
   end

   // Combs at the decimated rate.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ORDER; i++) comb_z_q[i] <= '0;
      end else if (dec_stb) begin
         comb_z_q[0] <= integ_q[ORDER-1];
         for (int i = 1; i < ORDER; i++) comb_z_q[i] <= diff[i-1];
      end
   end

   // Normalize gain OSR^ORDER to 2^(OUT_W-2) per code unit, then clip.
   always_comb begin
      wide_v = {{(SC_W-ACC_W){diff[ORDER-1][ACC_W-1]}}, diff[ORDER-1]};
      sh     = (OUT_W - 2) - ORDER * (MIN_OSR_LOG2 + int'(osr_sel));
      if (sh >= 0) scaled = wide_v <<< sh;
      else         scaled = wide_v >>> (-sh);
      if (scaled > SAT_HI)      sat_w = SAT_HI[OUT_W-1:0];
      else if (scaled < SAT_LO) sat_w = SAT_LO[OUT_W-1:0];
      else                      sat_w = scaled[OUT_W-1:0];
   end

   if (NARROW_W < OUT_W) begin : g_trim
      assign trimmed = wide ? sat_w
                            : {sat_w[OUT_W-1 -: NARROW_W], {(OUT_W-NARROW_W){1'b0}}};
   end else begin : g_full
      assign trimmed = sat_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word     <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= dec_stb;
         if (dec_stb) word <= trimmed;
      end
   end
endmodule

// File: rtl/dual_sinc_decimator.sv
module dual_sinc_decimator #(
   parameter int MIN_OSR_LOG2 = 5,
   parameter int SEL_W        = 2,
   parameter int CODE_W       = 3,
   parameter int OUT_W        = 24,
   parameter int NARROW_W     = 16,
   parameter int PH_W         = 8,
   parameter int ORDER        = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_tick,
   input  logic [SEL_W-1:0]  osr_sel,
   input  logic [PH_W-1:0]   phase,
   input  logic              width_ch0,
   input  logic              width_ch1,
   input  logic [CODE_W-1:0] mod_ch0,
   input  logic [CODE_W-1:0] mod_ch1,
   output logic [OUT_W-1:0]  data_ch0,
   output logic              valid_ch0,
   output logic [OUT_W-1:0]  data_ch1,
   output logic              valid_ch1
);
   localparam int MAX_LOG2 = dsd_pkg::max_log2(MIN_OSR_LOG2, SEL_W);

   if (PH_W < MAX_LOG2) begin : g_bad_phase
      $error("phase field too narrow for the largest ratio");
   end
   if (NARROW_W > OUT_W || NARROW_W < 1) begin : g_bad_narrow
      $error("narrow width must lie in 1..OUT_W");
   end
   if (MIN_OSR_LOG2 < 1) begin : g_bad_osr
      $error("smallest ratio must be at least 2");
   end

   logic                    dec_stb;
   logic [1:0][CODE_W-1:0]  raw_codes;
   logic [1:0][CODE_W-1:0]  dly_codes;
   logic [1:0]              wide_sel;
   logic [1:0][OUT_W-1:0]   words;
   logic [1:0]              vlds;

   assign raw_codes = {mod_ch1, mod_ch0};
   assign wide_sel  = {width_ch1, width_ch0};

   dsd_decim_timer #(.MIN_OSR_LOG2(MIN_OSR_LOG2), .SEL_W(SEL_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick),
      .osr_sel(osr_sel), .dec_stb(dec_stb)
   );

   dsd_phase_delay #(
      .MIN_OSR_LOG2(MIN_OSR_LOG2), .SEL_W(SEL_W), .CODE_W(CODE_W), .PH_W(PH_W)
   ) u_skew (
      .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick), .osr_sel(osr_sel),
      .phase_val(signed'(phase)), .codes_in(raw_codes), .codes_out(dly_codes)
   );

   for (genvar c = 0; c < 2; c++) begin : g_chan
      dsd_sinc3 #(
         .MIN_OSR_LOG2(MIN_OSR_LOG2), .SEL_W(SEL_W), .CODE_W(CODE_W),
         .OUT_W(OUT_W), .NARROW_W(NARROW_W), .ORDER(ORDER)
      ) u_filt (
         .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick), .dec_stb(dec_stb),
         .osr_sel(osr_sel), .wide(wide_sel[c]), .code(dly_codes[c]),
         .word(words[c]), .word_vld(vlds[c])
      );
   end

   assign data_ch0  = words[0];
   assign data_ch1  = words[1];
   assign valid_ch0 = vlds[0];
   assign valid_ch1 = vlds[1];
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
   parameter int MIN_OSR_LOG2 = 5,
   parameter int SEL_W        = 2,
   parameter int OUT_W        = 24,
   parameter int NARROW_W     = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mod_tick,
   input logic [SEL_W-1:0] osr_sel,
   input logic             width_ch0,
   input logic             width_ch1,
   input logic [OUT_W-1:0] data_ch0,
   input logic             valid_ch0,
   input logic [OUT_W-1:0] data_ch1,
   input logic             valid_ch1
);
   localparam int MAX_LOG2 = dsd_pkg::max_log2(MIN_OSR_LOG2, SEL_W);
   localparam int LOW_W    = (OUT_W > NARROW_W) ? OUT_W - NARROW_W : 1;

   logic [MAX_LOG2:0] tick_cnt_q;
   logic [MAX_LOG2:0] osr_val;
   logic              seen_q;

   assign osr_val = (MAX_LOG2+1)'(1) << (MIN_OSR_LOG2 + int'(osr_sel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_cnt_q <= '0;
         seen_q     <= 1'b0;
      end else begin
         if (valid_ch0) tick_cnt_q <= (MAX_LOG2+1)'(mod_tick);
         else           tick_cnt_q <= tick_cnt_q + (MAX_LOG2+1)'(mod_tick);
         if (valid_ch0) seen_q <= 1'b1;
      end
   end

   // R2
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_ch0 && seen_q) |-> (tick_cnt_q == osr_val));

   // R2
   strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_ch0 |-> $past(mod_tick));

   // R6
   lanes_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_ch0 == valid_ch1);

   // R6
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_ch0 |=> !valid_ch0);

   // R5
   narrow_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_ch0 && !$past(width_ch0)) |-> (data_ch0[LOW_W-1:0] == '0));

   // R5
   narrow_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_ch1 && !$past(width_ch1)) |-> (data_ch1[LOW_W-1:0] == '0));

   // R10
   hold_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_ch0 |-> $stable(data_ch0));

   // R10
   hold_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_ch1 |-> $stable(data_ch1));
endmodule

bind dual_sinc_decimator dsd_checker #(
   .MIN_OSR_LOG2(MIN_OSR_LOG2), .SEL_W(SEL_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)
) u_dsd_chk (
   .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick), .osr_sel(osr_sel),
   .width_ch0(width_ch0), .width_ch1(width_ch1),
   .data_ch0(data_ch0), .valid_ch0(valid_ch0),
   .data_ch1(data_ch1), .valid_ch1(valid_ch1)
);

// File: tb/dual_sinc_decimator_bench.sv
module dual_sinc_decimator_bench;
   localparam int WD_LIMIT = 150000;
   localparam int T0       = 40;
   localparam int NVEC     = 7;

   // {osr_sel, code0, code1, width0, width1, expect0, expect1}
   localparam logic [57:0] VEC [NVEC] = '{
      {2'd0, 3'h1, 3'h7, 1'b1, 1'b1, 24'h400000, 24'hC00000},
      {2'd1, 3'h2, 3'h6, 1'b1, 1'b1, 24'h7FFFFF, 24'h800000},
      {2'd2, 3'h0, 3'h1, 1'b1, 1'b0, 24'h000000, 24'h400000},
      {2'd3, 3'h7, 3'h2, 1'b1, 1'b0, 24'hC00000, 24'h7FFF00},
      {2'd3, 3'h2, 3'h6, 1'b0, 1'b0, 24'h7FFF00, 24'h800000},
      {2'd0, 3'h6, 3'h0, 1'b1, 1'b1, 24'h800000, 24'h000000},
      {2'd2, 3'h1, 3'h1, 1'b0, 1'b1, 24'h400000, 24'h400000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_tick = 1'b0;
   logic [1:0]  osr_sel = 2'd0;
   logic [7:0]  phase = 8'd0;
   logic        width_ch0 = 1'b1;
   logic        width_ch1 = 1'b1;
   logic [2:0]  mod_ch0 = 3'd0;
   logic [2:0]  mod_ch1 = 3'd0;
   logic [23:0] data_ch0;
   logic        valid_ch0;
   logic [23:0] data_ch1;
   logic        valid_ch1;

   int          n_checks = 0;
   int          n_errs   = 0;
   int          wd_cnt   = 0;
   logic [23:0] cap0 [8];
   logic [23:0] cap1 [8];
   logic [23:0] keep0 [8];
   logic [23:0] keep1 [8];
   int          capcyc [8];
   bit          hold_bad;
   bit          lane_bad;

   dual_sinc_decimator u_dual_sinc_decimator (
      .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick), .osr_sel(osr_sel),
      .phase(phase), .width_ch0(width_ch0), .width_ch1(width_ch1),
      .mod_ch0(mod_ch0), .mod_ch1(mod_ch1),
      .data_ch0(data_ch0), .valid_ch0(valid_ch0),
      .data_ch1(data_ch1), .valid_ch1(valid_ch1)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > WD_LIMIT) begin
         n_checks++;
         n_errs++;
         $display("FAIL R2 watchdog: actual=%0d cycles expected<=%0d", wd_cnt, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input logic [23:0] act,
                        input logic [23:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual=0x%06h expected=0x%06h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] code_at(input int t, input int start,
                                          input logic [2:0] c, input bit pat);
      if (pat) begin
         case (t % 7)
            0: return 3'h2;
            1: return 3'h7;
            2: return 3'h1;
            3: return 3'h0;
            4: return 3'h6;
            5: return 3'h2;
            default: return 3'h1;
         endcase
      end
      return (t >= start) ? c : 3'h0;
   endfunction

   task automatic run_cap(input logic [1:0] osr, input logic [7:0] ph,
                          input int s0, input int s1,
                          input logic [2:0] c0, input logic [2:0] c1,
                          input bit pat, input bit w0, input bit w1,
                          input bit gap, input int n_out);
      int k;
      int cyc;
      int got;
      bit mt;
      rst_n     = 1'b0;
      mod_tick  = 1'b0;
      osr_sel   = osr;
      phase     = ph;
      width_ch0 = w0;
      width_ch1 = w1;
      mod_ch0   = 3'h0;
      mod_ch1   = 3'h0;
      repeat (3) @(negedge clk);
      rst_n    = 1'b1;
      k        = 0;
      cyc      = 0;
      got      = 0;
      hold_bad = 1'b0;
      while (got < n_out) begin
         mt       = gap ? (cyc % 2 == 0) : 1'b1;
         mod_tick = mt;
         mod_ch0  = code_at(k, s0, c0, pat);
         mod_ch1  = code_at(k, s1, c1, pat);
         if (mt) k++;
         cyc++;
         @(negedge clk);
         if (valid_ch0 != valid_ch1) lane_bad = 1'b1;
         if (valid_ch0) begin
            cap0[got]   = data_ch0;
            cap1[got]   = data_ch1;
            capcyc[got] = cyc;
            got++;
         end else if (got > 0 &&
                      (data_ch0 != cap0[got-1] || data_ch1 != cap1[got-1])) begin
            hold_bad = 1'b1;
         end
      end
   endtask

   task automatic save_run(input int n);
      for (int i = 0; i < n; i++) begin
         keep0[i] = cap0[i];
         keep1[i] = cap1[i];
      end
   endtask

   task automatic compare_runs(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         check(cap0[i] == keep0[i], req, cap0[i], keep0[i]);
         check(cap1[i] == keep1[i], req, cap1[i], keep1[i]);
      end
   endtask

   initial begin
      lane_bad = 1'b0;

      // Table walk: settled constant inputs (R3, R4, R5) and word spacing (R2).
      for (int v = 0; v < NVEC; v++) begin
         logic [1:0]  osr;
         logic [2:0]  c0, c1;
         logic        w0, w1;
         logic [23:0] e0, e1;
         int          span;
         {osr, c0, c1, w0, w1, e0, e1} = VEC[v];
         run_cap(osr, 8'd0, 0, 0, c0, c1, 1'b0, w0, w1, 1'b0, 6);
         check(cap0[5] == e0, "R3 R4 R5 settled ch0", cap0[5], e0);
         check(cap1[5] == e1, "R3 R4 R5 settled ch1", cap1[5], e1);
         span = 32 << osr;
         check(capcyc[5] - capcyc[4] == span, "R2 word spacing",
               24'(capcyc[5] - capcyc[4]), 24'(span));
         check(!hold_bad, "R10 hold between strobes", 24'(hold_bad), 24'd0);
         if (v == 0) begin
            rst_n = 1'b0;
            #1;
            // R1: asynchronous reset clears both lanes at once
            check(data_ch0 == 24'd0 && data_ch1 == 24'd0, "R1 reset data",
                  data_ch0 | data_ch1, 24'd0);
            check(!valid_ch0 && !valid_ch1, "R1 reset strobe",
                  24'(valid_ch0 | valid_ch1), 24'd0);
         end
      end
      check(!lane_bad, "R6 strobes coincide", 24'(lane_bad), 24'd0);

      // R2: idle cycles between ticks stretch the spacing but not the result.
      run_cap(2'd0, 8'd0, 0, 0, 3'h1, 3'h7, 1'b0, 1'b1, 1'b1, 1'b1, 6);
      check(capcyc[5] - capcyc[4] == 64, "R2 gapped tick spacing",
            24'(capcyc[5] - capcyc[4]), 24'd64);
      check(cap0[5] == 24'h400000, "R2 R3 gapped value", cap0[5], 24'h400000);

      // R7: +5 skew equals channel 0 input arriving 5 ticks late.
      run_cap(2'd0, 8'd0, T0 + 5, T0, 3'h1, 3'h1, 1'b0, 1'b1, 1'b1, 1'b0, 6);
      save_run(6);
      run_cap(2'd0, 8'd5, T0, T0, 3'h1, 3'h1, 1'b0, 1'b1, 1'b1, 1'b0, 6);
      compare_runs("R7 positive skew", 6);

      // R8: -9 skew at ratio 64 delays channel 1.
      run_cap(2'd1, 8'd0, T0, T0 + 9, 3'h2, 3'h2, 1'b0, 1'b1, 1'b1, 1'b0, 6);
      save_run(6);
      run_cap(2'd1, 8'hF7, T0, T0, 3'h2, 3'h2, 1'b0, 1'b1, 1'b1, 1'b0, 6);
      compare_runs("R8 negative skew", 6);

      // R9: +40 at ratio 32 acts as +15.
      run_cap(2'd0, 8'd0, T0 + 15, T0, 3'h1, 3'h1, 1'b0, 1'b1, 1'b1, 1'b0, 6);
      save_run(6);
      run_cap(2'd0, 8'd40, T0, T0, 3'h1, 3'h1, 1'b0, 1'b1, 1'b1, 1'b0, 6);
      compare_runs("R9 clamp high", 6);

      // R9: -100 at ratio 32 acts as -16.
      run_cap(2'd0, 8'd0, T0, T0 + 16, 3'h1, 3'h1, 1'b0, 1'b1, 1'b1, 1'b0, 6);
      save_run(6);
      run_cap(2'd0, 8'h9C, T0, T0, 3'h1, 3'h1, 1'b0, 1'b1, 1'b1, 1'b0, 6);
      compare_runs("R9 clamp low", 6);

      // R5: narrow lane equals the upper bits of the wide lane on a busy stream.
      run_cap(2'd3, 8'd0, 0, 0, 3'h0, 3'h0, 1'b1, 1'b1, 1'b0, 1'b0, 5);
      for (int i = 0; i < 5; i++) begin
         check(cap1[i] == {cap0[i][23:8], 8'h00}, "R5 narrow truncation",
               cap1[i], {cap0[i][23:8], 8'h00});
      end

      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule